// File: doc/BRIEF.md
# Split-Write 64-bit Pointer Register Bank

This block is a small bank of 64-bit pointer registers behind a simple register write/read port. Software may load a pointer in one 64-bit access, or in two 32-bit accesses on buses that cannot carry 64 bits at once. In the split case the lower word is held in a side buffer and has no effect. The full pointer changes for downstream logic only when the upper word arrives, so a consumer never sees half of an old pointer mixed with half of a new one.

Each register drives a 64-bit committed value and a one-cycle update strobe, which tell consumers when a new pointer takes effect. A build parameter selects a 32-bit-addressing variant. In that variant, writes to the upper word are discarded, the upper word stays zero, and a lower-word write takes effect at once.

Top module: `ptr64_regbank`

## Requirements
- R1: After reset every committed value and every staged lower word is zero, and no update strobe is high.
- R2: A 64-bit write (wr_size=1) to a valid register offset replaces the whole committed value in the next cycle, and that register's strobe is high for exactly that cycle.
- R3: In the 64-bit build, a 32-bit write (wr_size=0) to the lower word (offset bit 2 = 0) changes neither the committed value nor any read result, and raises no strobe.
- R4: In the 64-bit build, a 32-bit write to the upper word (offset bit 2 = 1) commits {wr_data[31:0], staged lower word} in the next cycle and raises the strobe for one cycle.
- R5: An upper-word write that has no staged lower word pending keeps the current committed lower 32 bits.
- R6: Any commit, 64-bit or upper-word, discards a pending staged lower word.
- R7: Reads return committed state only. A 64-bit read returns the full value. A 32-bit read at bit 2 = 0 returns the lower word and at bit 2 = 1 the upper word, both zero-extended. An invalid read offset returns zero.
- R8: In the 32-bit build, upper-word writes are discarded, the upper 32 bits of every committed value stay zero, and no strobe follows an upper-word write.
- R9: In the 32-bit build, a lower-word write commits at once with a strobe, and a 64-bit write commits only its lower 32 bits.
- R10: Register i sits at byte offset 8*i. A write touches only the addressed register, so at most one strobe is high in any cycle.
- R11: A write is ignored when its offset has bits [1:0] nonzero, when its register index is NREGS or above, or when it is a 64-bit write with bit 2 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wr_size | input | 1 | Write size: 0 = 32-bit, 1 = 64-bit |
| wr_off | input | OFF_W | Write byte offset |
| wr_data | input | 64 | Write data; 32-bit writes use bits [31:0] |
| rd_size | input | 1 | Read size: 0 = 32-bit, 1 = 64-bit |
| rd_off | input | OFF_W | Read byte offset |
| rd_data | output | 64 | Combinational read data |
| ptr_val | output | NREGS*64 | Committed pointers, register i in bits [64*i+63:64*i] |
| ptr_upd | output | NREGS | One-cycle commit strobe per register |

## Verification
The bench builds two copies side by side with NREGS=4 and OFF_W=6. One copy uses ADDR64=1 and the other ADDR64=0, and both get the same stimulus in every cycle. This makes the difference between a staged lower word and one that commits at once visible within a single access. With OFF_W=6, offsets from 32 to 63 exist on the bus but decode to no register, so the out-of-range path can be driven. Random offsets up to 40 with random sizes mix split, whole, misaligned and out-of-range writes across all four registers.

// File: rtl/ptr64_pkg.sv
package ptr64_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_FULL = 2'd3
    } acc_e;

    typedef struct packed {
        logic [63:0] val;
        logic [31:0] stage_lo;
        logic        staged;
        logic        upd;
    } slot_t;
endpackage

// File: rtl/ptr64_dec.sv
module ptr64_dec
    import ptr64_pkg::*;
#(
    parameter int NREGS = 4,
    parameter int OFF_W = 6
) (
    input  logic             en,
    input  logic             size64,
    input  logic [OFF_W-1:0] off,
    output acc_e             kind,
    output logic [NREGS-1:0] sel
);
    localparam int IDX_W = OFF_W - 3;

    logic [IDX_W-1:0] idx;
    logic             ok;

    assign idx = off[OFF_W-1:3];

    always_comb begin
        ok = en && (off[1:0] == 2'b00) && (int'(idx) < NREGS)
             && !(size64 && off[2]);
        if (!ok)          kind = ACC_NONE;
        else if (size64)  kind = ACC_FULL;
        else if (off[2])  kind = ACC_HI;
        else              kind = ACC_LO;
        for (int i = 0; i < NREGS; i++) begin
            sel[i] = ok && (int'(idx) == i);
        end
    end
endmodule

// File: rtl/ptr64_slot.sv
module ptr64_slot
    import ptr64_pkg::*;
#(
    parameter bit ADDR64 = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  acc_e        kind,
    input  logic [63:0] data,
    output logic [63:0] val,
    output logic        upd
);
    slot_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        unique case (kind)
            ACC_FULL: begin
                st_d.val    = ADDR64 ? data : {32'd0, data[31:0]};
                st_d.staged = 1'b0;
                st_d.upd    = 1'b1;
            end
            ACC_LO: begin
                if (ADDR64) begin
                    st_d.stage_lo = data[31:0];
                    st_d.staged   = 1'b1;
                end else begin
                    st_d.val = {32'd0, data[31:0]};
                    st_d.upd = 1'b1;
                end
            end
            ACC_HI: begin
                if (ADDR64) begin
                    st_d.val    = {data[31:0],
                                   st_q.staged ? st_q.stage_lo : st_q.val[31:0]};
                    st_d.staged = 1'b0;
                    st_d.upd    = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.val;
    assign upd = st_q.upd;

    a_r2_full_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_FULL) |=> (upd && val[31:0] == $past(data[31:0])));

    a_r1_upd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(kind != ACC_NONE));

    generate
        if (ADDR64) begin : g_wide
            a_r3_lo_silent: assert property (@(posedge clk) disable iff (!rst_n)
                (kind == ACC_LO) |=> (!upd && $stable(val)));
            a_r4_hi_commit: assert property (@(posedge clk) disable iff (!rst_n)
                (kind == ACC_HI) |=> (upd && val[63:32] == $past(data[31:0])));
        end else begin : g_narrow
            a_r8_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
                val[63:32] == 32'd0);
            a_r8_hi_dropped: assert property (@(posedge clk) disable iff (!rst_n)
                (kind == ACC_HI) |=> (!upd && $stable(val)));
        end
    endgenerate
endmodule

// File: rtl/ptr64_regbank.sv
module ptr64_regbank
    import ptr64_pkg::*;
#(
    parameter int NREGS  = 4,
    parameter int OFF_W  = 6,
    parameter bit ADDR64 = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_size,
    input  logic [OFF_W-1:0]   wr_off,
    input  logic [63:0]        wr_data,
    input  logic               rd_size,
    input  logic [OFF_W-1:0]   rd_off,
    output logic [63:0]        rd_data,
    output logic [NREGS*64-1:0] ptr_val,
    output logic [NREGS-1:0]   ptr_upd
);
    acc_e             wr_kind, rd_kind;
    logic [NREGS-1:0] wr_sel, rd_sel;
    logic [63:0]      vals [NREGS];

    ptr64_dec #(.NREGS(NREGS), .OFF_W(OFF_W)) u_wdec (
        .en(wr_en), .size64(wr_size), .off(wr_off), .kind(wr_kind), .sel(wr_sel)
    );

    ptr64_dec #(.NREGS(NREGS), .OFF_W(OFF_W)) u_rdec (
        .en(1'b1), .size64(rd_size), .off(rd_off), .kind(rd_kind), .sel(rd_sel)
    );

    generate
        for (genvar i = 0; i < NREGS; i++) begin : g_slot
            acc_e kind_i;
            assign kind_i = wr_sel[i] ? wr_kind : ACC_NONE;
            ptr64_slot #(.ADDR64(ADDR64)) u_slot (
                .clk(clk), .rst_n(rst_n), .kind(kind_i), .data(wr_data),
                .val(vals[i]), .upd(ptr_upd[i])
            );
            assign ptr_val[64*i +: 64] = vals[i];
        end
    endgenerate

    always_comb begin
        logic [63:0] pick;
        pick = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_sel[i]) pick = vals[i];
        end
        unique case (rd_kind)
            ACC_FULL: rd_data = pick;
            ACC_LO:   rd_data = {32'd0, pick[31:0]};
            ACC_HI:   rd_data = {32'd0, pick[63:32]};
            default:  rd_data = '0;
        endcase
    end

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr_upd));

    a_r11_bad_off_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off[1:0] != 2'b00) |=> (ptr_upd == '0));
endmodule

// File: tb/ptr64_regbank_tb.sv
module ptr64_regbank_tb;
    localparam int CLK_NS = 10;
    localparam int N = 4;
    localparam int OW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_size = 1'b0, rd_size = 1'b0;
    logic [OW-1:0] wr_off = '0, rd_off = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd64, rd32;
    logic [N*64-1:0] pv64, pv32;
    logic [N-1:0] pu64, pu32;

    int n_chk = 0, n_bad = 0;
    logic [63:0] m64 [N];
    logic [63:0] m32 [N];
    logic [31:0] stg [N];
    logic        stv [N];
    logic [N-1:0] eu64, eu32;

    always #(CLK_NS/2) clk = ~clk;

    ptr64_regbank #(.NREGS(N), .OFF_W(OW), .ADDR64(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size), .wr_off(wr_off),
        .wr_data(wr_data), .rd_size(rd_size), .rd_off(rd_off), .rd_data(rd64),
        .ptr_val(pv64), .ptr_upd(pu64));

    ptr64_regbank #(.NREGS(N), .OFF_W(OW), .ADDR64(1'b0)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_size), .wr_off(wr_off),
        .wr_data(wr_data), .rd_size(rd_size), .rd_off(rd_off), .rd_data(rd32),
        .ptr_val(pv32), .ptr_upd(pu32));

    // 0 none, 1 low word, 2 high word, 3 full
    function automatic int kind_of(logic sz, logic [OW-1:0] off);
        if (off[1:0] != 2'b00 || int'(off[OW-1:3]) >= N) return 0;
        if (sz) return off[2] ? 0 : 3;
        return off[2] ? 2 : 1;
    endfunction

    function automatic logic [63:0] rd_exp(logic [63:0] v, logic sz, logic [OW-1:0] off);
        case (kind_of(sz, off))
            3: return v;
            1: return {32'd0, v[31:0]};
            2: return {32'd0, v[63:32]};
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_apply(logic en, logic sz, logic [OW-1:0] off, logic [63:0] d);
        int k, ix;
        eu64 = '0; eu32 = '0;
        k = en ? kind_of(sz, off) : 0;
        ix = int'(off[OW-1:3]);
        if (k == 3) begin
            m64[ix] = d; stv[ix] = 1'b0; eu64[ix] = 1'b1;
            m32[ix] = {32'd0, d[31:0]}; eu32[ix] = 1'b1;
        end else if (k == 1) begin
            stg[ix] = d[31:0]; stv[ix] = 1'b1;
            m32[ix] = {32'd0, d[31:0]}; eu32[ix] = 1'b1;
        end else if (k == 2) begin
            m64[ix] = {d[31:0], stv[ix] ? stg[ix] : m64[ix][31:0]};
            stv[ix] = 1'b0; eu64[ix] = 1'b1;
        end
    endtask

    task automatic compare_all(string tag);
        for (int i = 0; i < N; i++) begin
            check(pv64[64*i +: 64] === m64[i], tag, pv64[64*i +: 64], m64[i]);
            check(pv32[64*i +: 64] === m32[i], tag, pv32[64*i +: 64], m32[i]);
        end
        check(pu64 === eu64, tag, 64'(pu64), 64'(eu64));
        check(pu32 === eu32, tag, 64'(pu32), 64'(eu32));
        check(rd64 === rd_exp(m64[int'(rd_off[OW-1:3]) % N], rd_size, rd_off), tag,
              rd64, rd_exp(m64[int'(rd_off[OW-1:3]) % N], rd_size, rd_off));
        check(rd32 === rd_exp(m32[int'(rd_off[OW-1:3]) % N], rd_size, rd_off), tag,
              rd32, rd_exp(m32[int'(rd_off[OW-1:3]) % N], rd_size, rd_off));
    endtask

    // drive at negedge, commit at posedge, check at following negedge
    task automatic step(logic en, logic sz, logic [OW-1:0] off, logic [63:0] d,
                        logic rsz, logic [OW-1:0] roff, string tag);
        wr_en = en; wr_size = sz; wr_off = off; wr_data = d;
        rd_size = rsz; rd_off = roff;
        @(posedge clk);
        model_apply(en, sz, off, d);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m64[i] = '0; m32[i] = '0; stg[i] = '0; stv[i] = 1'b0;
        end
        eu64 = '0; eu32 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1 reset state");
        step(1'b0, 1'b0, 6'd0, 64'd0, 1'b1, 6'd8, "R1 idle after reset");

        step(1'b1, 1'b1, 6'd8, 64'h1122_3344_5566_7788, 1'b1, 6'd8, "R2 full write reg1");
        step(1'b0, 1'b0, 6'd0, 64'd0, 1'b0, 6'd12, "R2 strobe single cycle / R7 hi read");
        step(1'b1, 1'b0, 6'd0, 64'h0000_0000_AAAA_0000, 1'b0, 6'd0, "R3 low stage reg0 / R9 narrow commit");
        step(1'b1, 1'b0, 6'd4, 64'h0000_0000_BBBB_0001, 1'b1, 6'd0, "R4 high commit reg0 / R8 narrow drop");
        step(1'b1, 1'b1, 6'd16, 64'hCAFE_0000_1234_5678, 1'b0, 6'd16, "R2 full reg2");
        step(1'b1, 1'b0, 6'd20, 64'h0000_0000_0000_BEEF, 1'b1, 6'd16, "R5 high without staged low");
        step(1'b1, 1'b0, 6'd24, 64'h0000_0000_5555_5555, 1'b1, 6'd24, "R6 stage reg3");
        step(1'b1, 1'b1, 6'd24, 64'h0F0F_0F0F_F0F0_F0F0, 1'b1, 6'd24, "R6 full discards stage");
        step(1'b1, 1'b0, 6'd28, 64'h0000_0000_7777_7777, 1'b1, 6'd24, "R6 high uses committed low");
        step(1'b1, 1'b0, 6'd9, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 6'd9, "R11 misaligned ignored / R7 bad read");
        step(1'b1, 1'b1, 6'd12, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd12, "R11 full at bit2 ignored");
        step(1'b1, 1'b1, 6'd40, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd8, "R11 out of range ignored / R10");
        step(1'b1, 1'b0, 6'd28, 64'h0000_0000_9999_9999, 1'b0, 6'd28, "R8 narrow high dropped / R10 one strobe");

        for (int n = 0; n < 3000; n++) begin
            logic [OW-1:0] o, ro;
            o  = 6'($urandom % 41);
            if ($urandom % 4 != 0) o[1:0] = 2'b00;
            ro = 6'($urandom % 41);
            if ($urandom % 4 != 0) ro[1:0] = 2'b00;
            step(1'($urandom % 4 != 0), 1'($urandom % 2), o,
                 {$urandom, $urandom}, 1'($urandom % 2), ro, "R2-mix random R7 R10");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule